// File: doc/BRIEF.md
# Hardware Barrier Synchronizer

This block gathers a fixed group of agents at a common rendezvous point. The group size is set by a parameter. Each agent raises its own bit of an arrival vector for one cycle and then waits for the group to be released.

Arrivals are passed one at a time through a fixed-priority arbiter, which acts as the lock around a shared arrival counter. Each granted arrival is handed the counter value as it stood before the increment, and this value is its ticket. The first arrival of a round lowers the shared release flag. The arrival that fills the group resets the counter, raises the flag again, clears every agent's waiting bit and produces a one-cycle release pulse.

An agent that signals arrival while it is still waiting is ignored, and the block records the mistake in a sticky error bit.

Top module: `barrier_sync_unit`

## Requirements
- R1: After reset, `waiting_o`, `release_flag_o`, `release_o`, `grant_valid_o` and `error_o` are all low, and the counter is zero.
- R2: An accepted arrival of agent i (bit i of `arrive_i`) sets `waiting_o[i]` from the clock edge that samples it.
- R3: Requests that arrive together are granted one per cycle, lowest agent index first. A request that is not granted is held pending until it is granted. The grant made at an edge appears on `grant_valid_o` and `grant_id_o` (the agent index) after that edge.
- R4: Each grant's `grant_ticket_o` is the counter value before the increment. Within a round the tickets therefore run 0, 1, …, N_AGENTS-1 in grant order.
- R5: The grant with ticket 0 lowers `release_flag_o` at the same edge.
- R6: The grant with ticket N_AGENTS-1 does all of the following at the same edge: it resets the counter to zero, raises `release_flag_o`, clears every `waiting_o` bit and raises `release_o`. `release_o` is high for exactly that one cycle.
- R7: An arrival from an agent whose `waiting_o` bit is set produces no grant and leaves the counter unchanged. It raises `error_o`, which stays high until reset.
- R8: `release_flag_o` stays high after a release until the next round's first grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arrive_i | input | N_AGENTS | One-cycle arrival pulse per agent, bit index = agent index |
| grant_valid_o | output | 1 | An arrival was granted at the last edge |
| grant_id_o | output | max(1,clog2(N_AGENTS)) | Index of the granted agent |
| grant_ticket_o | output | max(1,clog2(N_AGENTS)) | Counter value before the increment for that grant |
| release_o | output | 1 | One-cycle pulse when the group completes |
| release_flag_o | output | 1 | Shared release flag |
| waiting_o | output | N_AGENTS | Per-agent waiting bits |
| error_o | output | 1 | Sticky flag: an agent arrived while still waiting |

## Verification
A counter that has drifted shows up at the next grant as a wrong ticket. It also shows up at the end of the round as a release pulse that fires early or late. A lost pending request appears within N_AGENTS cycles as a missing grant and a round that never releases. A waiting bit left set appears as a false error on that agent's next arrival. A flag stuck at one value is visible at the very next first-of-round grant or at the next release.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
    // Index width that stays legal for a group of one.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/bsu_arrive_filter.sv
module bsu_arrive_filter #(
    parameter int N_AGENTS = 4
) (
    input  logic [N_AGENTS-1:0] arrive_i,
    input  logic [N_AGENTS-1:0] waiting_i,
    output logic [N_AGENTS-1:0] accept_o,
    output logic                dup_o
);
    logic [N_AGENTS-1:0] dup_vec;

    for (genvar g = 0; g < N_AGENTS; g++) begin : g_agent
        assign accept_o[g] = arrive_i[g] & ~waiting_i[g];
        assign dup_vec[g]  = arrive_i[g] &  waiting_i[g];
    end

    assign dup_o = |dup_vec;
endmodule

// File: rtl/bsu_prio_arb.sv
module bsu_prio_arb #(
    parameter int N_AGENTS = 4,
    parameter int IW       = 2
) (
    input  logic [N_AGENTS-1:0] req_i,
    output logic [N_AGENTS-1:0] gnt_o,
    output logic                any_o,
    output logic [IW-1:0]       idx_o
);
    logic [N_AGENTS:0] seen;

    assign seen[0] = 1'b0;
    for (genvar g = 0; g < N_AGENTS; g++) begin : g_chain
        assign gnt_o[g]    = req_i[g] & ~seen[g];
        assign seen[g + 1] = seen[g] | req_i[g];
    end
    assign any_o = seen[N_AGENTS];

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N_AGENTS; i++) begin
            if (gnt_o[i]) idx_o = idx_o | IW'(i);
        end
    end
endmodule

// File: rtl/barrier_sync_unit.sv
module barrier_sync_unit #(
    parameter int N_AGENTS = 4,
    localparam int IW = bsu_pkg::idx_width(N_AGENTS)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [N_AGENTS-1:0] arrive_i,
    output logic                grant_valid_o,
    output logic [IW-1:0]       grant_id_o,
    output logic [IW-1:0]       grant_ticket_o,
    output logic                release_o,
    output logic                release_flag_o,
    output logic [N_AGENTS-1:0] waiting_o,
    output logic                error_o
);
    localparam logic [IW-1:0] LAST_TICKET = IW'(N_AGENTS - 1);

    typedef struct packed {
        logic [N_AGENTS-1:0] pending;
        logic [N_AGENTS-1:0] waiting;
        logic [IW-1:0]       count;
        logic                flag;
        logic                rel;
        logic                gvalid;
        logic [IW-1:0]       gid;
        logic [IW-1:0]       gticket;
        logic                err;
    } state_t;

    state_t state_d, state_q;

    logic [N_AGENTS-1:0] accepted;
    logic                dup_any;
    logic [N_AGENTS-1:0] req;
    logic [N_AGENTS-1:0] gnt;
    logic                gnt_any;
    logic [IW-1:0]       gnt_idx;

    bsu_arrive_filter #(.N_AGENTS(N_AGENTS)) i_filter (
        .arrive_i (arrive_i),
        .waiting_i(state_q.waiting),
        .accept_o (accepted),
        .dup_o    (dup_any)
    );

    assign req = state_q.pending | accepted;

    bsu_prio_arb #(.N_AGENTS(N_AGENTS), .IW(IW)) i_arb (
        .req_i(req),
        .gnt_o(gnt),
        .any_o(gnt_any),
        .idx_o(gnt_idx)
    );

    always_comb begin
        state_d         = state_q;
        state_d.rel     = 1'b0;
        state_d.gvalid  = gnt_any;
        state_d.gid     = gnt_idx;
        state_d.gticket = state_q.count;
        state_d.waiting = state_q.waiting | accepted;
        state_d.pending = req & ~gnt;
        state_d.err     = state_q.err | dup_any;
        if (gnt_any) begin
            if (state_q.count == '0) begin
                state_d.flag = 1'b0;
            end
            if (state_q.count == LAST_TICKET) begin
                state_d.count   = '0;
                state_d.flag    = 1'b1;
                state_d.rel     = 1'b1;
                state_d.waiting = '0;
            end else begin
                state_d.count = state_q.count + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign grant_valid_o  = state_q.gvalid;
    assign grant_id_o     = state_q.gid;
    assign grant_ticket_o = state_q.gticket;
    assign release_o      = state_q.rel;
    assign release_flag_o = state_q.flag;
    assign waiting_o      = state_q.waiting;
    assign error_o        = state_q.err;
endmodule

// File: rtl/bsu_checker.sv
module bsu_checker #(
    parameter int N_AGENTS = 4,
    parameter int IW       = 2
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                grant_valid_o,
    input logic [IW-1:0]       grant_id_o,
    input logic [IW-1:0]       grant_ticket_o,
    input logic                release_o,
    input logic                release_flag_o,
    input logic [N_AGENTS-1:0] waiting_o,
    input logic                error_o
);
    p_release_clears_wait_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        release_o |-> (waiting_o == '0) && release_flag_o);

    p_release_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        release_o |=> !release_o);

    p_release_last_ticket_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        release_o |-> grant_valid_o && (grant_ticket_o == IW'(N_AGENTS - 1)));

    p_first_clears_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (grant_valid_o && grant_ticket_o == '0) |-> !release_flag_o);

    p_grant_is_waiting_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (grant_valid_o && !release_o) |-> waiting_o[grant_id_o]);

    p_error_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        error_o |=> error_o);
endmodule

bind barrier_sync_unit bsu_checker #(.N_AGENTS(N_AGENTS), .IW(IW)) i_bsu_checker (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .grant_valid_o (grant_valid_o),
    .grant_id_o    (grant_id_o),
    .grant_ticket_o(grant_ticket_o),
    .release_o     (release_o),
    .release_flag_o(release_flag_o),
    .waiting_o     (waiting_o),
    .error_o       (error_o)
);

// File: tb/test_barrier_sync_unit.sv
module test_barrier_sync_unit;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  arrive = '0;
    logic          gvalid;
    logic [IW-1:0] gid;
    logic [IW-1:0] gticket;
    logic          rel;
    logic          flag;
    logic [N-1:0]  waiting;
    logic          err;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    barrier_sync_unit #(.N_AGENTS(N)) i_barrier_sync_unit (
        .clk_i(clk), .rst_ni(rst_n), .arrive_i(arrive),
        .grant_valid_o(gvalid), .grant_id_o(gid), .grant_ticket_o(gticket),
        .release_o(rel), .release_flag_o(flag), .waiting_o(waiting), .error_o(err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one arrival vector across one edge, then sample just after it.
    task automatic step(input logic [N-1:0] a);
        @(negedge clk);
        arrive = a;
        @(posedge clk);
        #1;
        arrive = '0;
    endtask

    task automatic expect_grant(input string tag, input int id, input int tk,
                                input logic r, input logic f, input logic [N-1:0] w);
        chk({tag, " grant_valid"}, 32'(gvalid), 32'd1);
        chk({tag, " grant_id"}, 32'(gid), 32'(id));
        chk({tag, " ticket"}, 32'(gticket), 32'(tk));
        chk({tag, " release"}, 32'(rel), 32'(r));
        chk({tag, " flag"}, 32'(flag), 32'(f));
        chk({tag, " waiting"}, 32'(waiting), 32'(w));
    endtask

    task automatic t_reset();
        chk("R1 waiting", 32'(waiting), 32'd0);
        chk("R1 flag", 32'(flag), 32'd0);
        chk("R1 release", 32'(rel), 32'd0);
        chk("R1 grant_valid", 32'(gvalid), 32'd0);
        chk("R1 error", 32'(err), 32'd0);
    endtask

    task automatic t_simultaneous();
        step(4'b1111);
        expect_grant("R3 R5 first of four", 0, 0, 1'b0, 1'b0, 4'b1111);
        step(4'b0000);
        expect_grant("R3 R4 pending agent1", 1, 1, 1'b0, 1'b0, 4'b1111);
        step(4'b0000);
        expect_grant("R3 R4 pending agent2", 2, 2, 1'b0, 1'b0, 4'b1111);
        step(4'b0000);
        expect_grant("R6 last arrival", 3, 3, 1'b1, 1'b1, 4'b0000);
        step(4'b0000);
        chk("R6 release one cycle", 32'(rel), 32'd0);
        chk("R8 flag held", 32'(flag), 32'd1);
        chk("R3 no spare grant", 32'(gvalid), 32'd0);
        step(4'b0000);
        chk("R8 flag held idle", 32'(flag), 32'd1);
    endtask

    task automatic t_staggered();
        step(4'b0100);
        expect_grant("R5 R2 round2 first", 2, 0, 1'b0, 1'b0, 4'b0100);
        step(4'b0001);
        expect_grant("R4 round2 second", 0, 1, 1'b0, 1'b0, 4'b0101);
        step(4'b1010);
        expect_grant("R3 round2 pair", 1, 2, 1'b0, 1'b0, 4'b1111);
        step(4'b0000);
        expect_grant("R6 round2 last", 3, 3, 1'b1, 1'b1, 4'b0000);
        chk("R7 no error yet", 32'(err), 32'd0);
    endtask

    task automatic t_duplicate();
        step(4'b0010);
        expect_grant("R5 round3 first", 1, 0, 1'b0, 1'b0, 4'b0010);
        step(4'b0010);
        chk("R7 duplicate no grant", 32'(gvalid), 32'd0);
        chk("R7 error set", 32'(err), 32'd1);
        chk("R7 waiting unchanged", 32'(waiting), 32'b0010);
        step(4'b1101);
        expect_grant("R7 counter unchanged", 0, 1, 1'b0, 1'b0, 4'b1111);
        step(4'b0000);
        expect_grant("R3 round3 held", 2, 2, 1'b0, 1'b0, 4'b1111);
        step(4'b0000);
        expect_grant("R6 round3 last", 3, 3, 1'b1, 1'b1, 4'b0000);
        chk("R7 error sticky", 32'(err), 32'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog R1..R8 actual=timeout expected=complete");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        t_simultaneous();
        t_staggered();
        t_duplicate();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule